// File: doc/BRIEF.md
# Asynchronous SRAM Bus Timing Monitor

A passive observer for the control side of an asynchronous static RAM bus. It samples both chip enables, the write strobe, the output strobe, the two byte-lane selects, the address bus and a flag that says the host is driving the data lines, all on one fast reference clock. It drives nothing on the bus and keeps no copy of the memory. Lengths are counted in reference-clock ticks and compared against a parameter limit for each rule. A broken rule sets its own sticky flag. It also raises a one-tick pulse and advances a saturating event count.

The write window is the overlap of the low-active enable being low, the high-active enable being high and the write strobe being low. It opens when the last of the three arrives and closes on the first sample where any one of them has left. All end-of-write rules are judged on that closing sample. Flags hold until the clear input is pulsed.

Top module: `sram_timing_mon`

## Requirements
- R1: On the sample where the write window closes, flag bit 0 is set if the window lasted fewer than `T_WP` samples. This holds whichever of the three signals closed it.
- R2: Flag bit 1 is set on window close if the chip has been selected for fewer than `T_CW` samples up to the close. Selection means both enables active, so it counts from the later of the two enables.
- R3: Flag bit 2 is set on window close if at least one lane select (`lane_n` bit low) has not been held for `T_BW` consecutive samples up to the close.
- R4: Flag bit 3 is set on any sample where `wstrobe_n` is low and `addr` differs from the previous sample.
- R5: Flag bit 4 is set if `addr` changes on any of the `T_WR` samples that start with the closing sample. When `T_WR` is 0 this rule never fires.
- R6: Flag bit 5 is set on window close if `host_drv` has not been high for `T_DS` consecutive samples up to the close.
- R7: Flag bit 6 is set if `host_drv` is low on any of the `T_DH` samples that start with the closing sample. It fires at most once per window.
- R8: Flag bit 7 is set on any sample where `host_drv` is high, `ostrobe_n` is low, `wstrobe_n` is high and the chip is selected. It is not set when the chip is deselected.
- R9: A flag appears one clock after the offending sample and stays set until `clr` is sampled high. `clr` clears every flag and takes priority over a violation in the same sample.
- R10: `viol_cnt` rises by one for each sample with at least one violation. It saturates at 2^`CNT_W`-1, and `clr` forces it to zero with priority.
- R11: `viol_pulse` is high for exactly one clock after each violating sample, whether or not `clr` is present.
- R12: After reset all flags, the count and the pulse are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears flags and count |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| wstrobe_n | input | 1 | Write strobe, active low |
| ostrobe_n | input | 1 | Output strobe, active low |
| lane_n | input | 2 | Byte-lane selects, active low |
| addr | input | ADDR_W | Address bus |
| host_drv | input | 1 | High while the host drives the data lines |
| viol | output | 8 | Sticky per-rule flags |
| viol_pulse | output | 1 | One-clock pulse per violating sample |
| viol_cnt | output | CNT_W | Saturating violation count |

## Verification
The hardest situation to reach is a write window that closes on each of its three possible edges while the enables, lane selects and host drive each have their own lead time. Address moves must also fall just before, on and just after the closing sample. The bench lays out every run on a timeline fixed to one closing sample. It picks which signal ends the window and sweeps window length, enable lead, lane lead, drive lead, drive hold and address-change offset around that sample. The expected flag set and violation-sample count are derived arithmetically from the same offsets.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;
  localparam int NRULE      = 8;
  localparam int R_WPULSE   = 0;
  localparam int R_SELEND   = 1;
  localparam int R_LANEEND  = 2;
  localparam int R_ADDRMOV  = 3;
  localparam int R_RECOV    = 4;
  localparam int R_DSETUP   = 5;
  localparam int R_DHOLD    = 6;
  localparam int R_BUSFIGHT = 7;

  localparam int NRUN     = 4;
  localparam int RUN_WIN  = 0;
  localparam int RUN_SEL  = 1;
  localparam int RUN_LANE = 2;
  localparam int RUN_HOST = 3;
endpackage

// File: rtl/mon_run_len.sv
// Length of the current (or most recent) run of a level, saturating.
module mon_run_len #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lvl,
  output logic         lvl_q,
  output logic [W-1:0] len
);
  localparam logic [W-1:0] LMAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      len   <= '0;
    end else begin
      lvl_q <= lvl;
      if (lvl) begin
        if (!lvl_q)          len <= W'(1);
        else if (len != LMAX) len <= len + W'(1);
      end
    end
  end

  // R2: a new run restarts the count at one
  p_run_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (lvl && !lvl_q) |=> (len == W'(1)));
  // R2: the length is frozen while the level is low
  p_run_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !lvl |=> $stable(len));
endmodule

// File: rtl/mon_post_win.sv
// Watches a condition for LEN samples starting at the start strobe.
module mon_post_win #(
  parameter int LEN = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic bad,
  output logic hit
);
  localparam int RW = $clog2(LEN + 2);
  localparam logic [RW-1:0] RELOAD = RW'((LEN > 0) ? LEN - 1 : 0);

  logic [RW-1:0] rem;
  logic          active;

  always_comb begin
    active = start | (rem != '0);
    hit    = active & bad & (LEN != 0);
  end

  always_ff @(posedge clk) begin
    if (rst)                rem <= '0;
    else if (hit)           rem <= '0;
    else if (start)         rem <= RELOAD;
    else if (rem != '0)     rem <= rem - RW'(1);
  end

  // R7: the countdown steps by one while no new start or hit occurs
  p_rem_count_r7: assert property (@(posedge clk) disable iff (rst)
    (rem != '0 && !start && !hit) |=> (rem == $past(rem) - RW'(1)));

  if (LEN == 0) begin : g_off
    // R5: a zero-length window never reports
    p_rec_off_r5: assert property (@(posedge clk) disable iff (rst) !hit);
  end
endmodule

// File: rtl/sram_timing_mon.sv
module sram_timing_mon
  import sram_mon_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 16,
  parameter int T_WP   = 5,
  parameter int T_CW   = 9,
  parameter int T_BW   = 4,
  parameter int T_DS   = 4,
  parameter int T_DH   = 0,
  parameter int T_WR   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              wstrobe_n,
  input  logic              ostrobe_n,
  input  logic [1:0]        lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              host_drv,
  output logic [NRULE-1:0]  viol,
  output logic              viol_pulse,
  output logic [CNT_W-1:0]  viol_cnt
);
  function automatic int imax2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TMAX  = imax2(imax2(T_WP, T_CW), imax2(T_BW, T_DS));
  localparam int RUN_W = $clog2(TMAX + 1) + 1;
  localparam logic [RUN_W-1:0] LIM_WP = RUN_W'(T_WP);
  localparam logic [RUN_W-1:0] LIM_CW = RUN_W'(T_CW);
  localparam logic [RUN_W-1:0] LIM_BW = RUN_W'(T_BW);
  localparam logic [RUN_W-1:0] LIM_DS = RUN_W'(T_DS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic sel, win, lane_on;
  logic [NRUN-1:0]  lv, lvq;
  logic [RUN_W-1:0] rl [NRUN];

  always_comb begin
    sel     = ~sel_a_n & sel_b;
    win     = sel & ~wstrobe_n;
    lane_on = ~(&lane_n);
    lv           = '0;
    lv[RUN_WIN]  = win;
    lv[RUN_SEL]  = sel;
    lv[RUN_LANE] = lane_on;
    lv[RUN_HOST] = host_drv;
  end

  for (genvar g = 0; g < NRUN; g++) begin : g_run
    mon_run_len #(.W(RUN_W)) u_run (
      .clk   (clk),
      .rst   (rst),
      .lvl   (lv[g]),
      .lvl_q (lvq[g]),
      .len   (rl[g])
    );
  end

  logic win_end;
  assign win_end = lvq[RUN_WIN] & ~win;

  logic [ADDR_W-1:0] addr_q;
  logic              addr_ok, addr_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      addr_ok <= 1'b0;
    end else begin
      addr_q  <= addr;
      addr_ok <= 1'b1;
    end
  end

  assign addr_chg = addr_ok & (addr != addr_q);

  logic hit_rec, hit_dh;

  mon_post_win #(.LEN(T_WR)) u_recov (
    .clk   (clk),
    .rst   (rst),
    .start (win_end),
    .bad   (addr_chg),
    .hit   (hit_rec)
  );

  mon_post_win #(.LEN(T_DH)) u_dhold (
    .clk   (clk),
    .rst   (rst),
    .start (win_end),
    .bad   (~host_drv),
    .hit   (hit_dh)
  );

  logic [NRULE-1:0] hit;

  always_comb begin
    hit             = '0;
    hit[R_WPULSE]   = win_end & (rl[RUN_WIN] < LIM_WP);
    hit[R_SELEND]   = win_end & (~lvq[RUN_SEL] | (rl[RUN_SEL] < LIM_CW));
    hit[R_LANEEND]  = win_end & (~lvq[RUN_LANE] | (rl[RUN_LANE] < LIM_BW));
    hit[R_DSETUP]   = win_end & (~lvq[RUN_HOST] | (rl[RUN_HOST] < LIM_DS));
    hit[R_ADDRMOV]  = ~wstrobe_n & addr_chg;
    hit[R_RECOV]    = hit_rec;
    hit[R_DHOLD]    = hit_dh;
    hit[R_BUSFIGHT] = host_drv & ~ostrobe_n & sel & wstrobe_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol       <= '0;
      viol_pulse <= 1'b0;
      viol_cnt   <= '0;
    end else begin
      viol_pulse <= |hit;
      if (clr) begin
        viol     <= '0;
        viol_cnt <= '0;
      end else begin
        viol <= viol | hit;
        if ((|hit) && (viol_cnt != CNT_MAX)) viol_cnt <= viol_cnt + CNT_W'(1);
      end
    end
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((viol & $past(viol)) == $past(viol)));
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (viol == '0 && viol_cnt == '0));
  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (viol_cnt == CNT_MAX && !clr) |=> (viol_cnt == CNT_MAX));
  p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |-> (viol != '0 || $past(clr)));
  p_bus_r8: assert property (@(posedge clk) disable iff (rst)
    (host_drv && !ostrobe_n && !sel_a_n && sel_b && wstrobe_n && !clr) |=> viol[R_BUSFIGHT]);
  p_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (!wstrobe_n && addr_chg && !clr) |=> viol[R_ADDRMOV]);
  p_wp_r1: assert property (@(posedge clk) disable iff (rst)
    (win_end && rl[RUN_WIN] < LIM_WP && !clr) |=> viol[R_WPULSE]);
endmodule

// File: tb/sram_timing_mon_tb_top.sv
module sram_timing_mon_tb_top;
  localparam int AW   = 4;
  localparam int CW   = 3;
  localparam int T_WP = 3;
  localparam int T_CW = 5;
  localparam int T_BW = 2;
  localparam int T_DS = 2;
  localparam int T_DH = 2;
  localparam int T_WR = 2;
  localparam int E    = 12;
  localparam int N    = E + 6;
  localparam int NONE = 99;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, clr, sel_a_n, sel_b, wstrobe_n, ostrobe_n, host_drv;
  logic [1:0]    lane_n;
  logic [AW-1:0] addr;
  logic [7:0]    viol;
  logic          viol_pulse;
  logic [CW-1:0] viol_cnt;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  string tags [8] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R8"};

  sram_timing_mon #(
    .ADDR_W(AW), .CNT_W(CW), .T_WP(T_WP), .T_CW(T_CW), .T_BW(T_BW),
    .T_DS(T_DS), .T_DH(T_DH), .T_WR(T_WR)
  ) dut_i (
    .clk(clk), .rst(rst), .clr(clr), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .wstrobe_n(wstrobe_n), .ostrobe_n(ostrobe_n), .lane_n(lane_n),
    .addr(addr), .host_drv(host_drv), .viol(viol), .viol_pulse(viol_pulse),
    .viol_cnt(viol_cnt)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    sel_a_n = 1'b1; sel_b = 1'b0; wstrobe_n = 1'b1; ostrobe_n = 1'b1;
    lane_n = 2'b11; host_drv = 1'b0;
  endtask

  // One write run laid out around closing sample E.
  task automatic run_write(input int wlen, input int cs_lead, input int bs_len,
                           input int hd_len, input int hd_hold, input int endm,
                           input int chg_off, input bit oe_lo);
    logic [7:0] ef;
    int  marks, pulses, cs_start;
    bit  dh_done;
    ef = '0; marks = 0; pulses = 0; dh_done = 0;
    cs_start = E - wlen - cs_lead;
    @(negedge clk); idle(); clr = 1'b1;
    for (int t = 0; t < N; t++) begin
      bit a_on, b_on, s_on, w_on, l_on, h_on, mk;
      @(negedge clk);
      clr = 1'b0;
      if (viol_pulse) pulses++;
      a_on = (t >= cs_start) && (t <= ((endm == 1) ? E - 1 : E));
      b_on = (t >= cs_start - 2) && (t <= ((endm == 2) ? E - 1 : E));
      s_on = a_on && b_on;
      w_on = (t >= E - wlen) && (t <= ((endm == 0) ? E - 1 : E));
      l_on = (bs_len > 0) && (t >= E - bs_len) && (t <= E - 1);
      h_on = (hd_len > 0) && (t >= E - hd_len) && (t <= E - 1 + hd_hold);
      mk = 0;
      if (t == E) begin
        if (wlen < T_WP)           begin ef[0] = 1; mk = 1; end
        if (wlen + cs_lead < T_CW) begin ef[1] = 1; mk = 1; end
        if (bs_len < T_BW)         begin ef[2] = 1; mk = 1; end
        if (hd_len < T_DS)         begin ef[5] = 1; mk = 1; end
      end
      if (t >= E && t < E + T_DH && !h_on && !dh_done) begin
        ef[6] = 1; mk = 1; dh_done = 1;
      end
      if (chg_off != NONE && t == E + chg_off) begin
        addr = addr + AW'(1);
        if (w_on) begin ef[3] = 1; mk = 1; end
        if (t >= E && t < E + T_WR) begin ef[4] = 1; mk = 1; end
      end
      if (h_on && oe_lo && s_on && !w_on) begin ef[7] = 1; mk = 1; end
      if (mk) marks++;
      sel_a_n   = ~a_on;
      sel_b     = b_on;
      wstrobe_n = ~w_on;
      ostrobe_n = ~oe_lo;
      lane_n    = l_on ? ((bs_len % 2 == 1) ? 2'b10 : 2'b01) : 2'b11;
      host_drv  = h_on;
    end
    repeat (6) begin
      @(negedge clk);
      if (viol_pulse) pulses++;
    end
    for (int b = 0; b < 8; b++) check_eq(tags[b], int'(viol[b]), int'(ef[b]));
    check_eq("R10", int'(viol_cnt), (marks > 7) ? 7 : marks);
    check_eq("R11", pulses, marks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R12 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int pulses;
    rst = 1'b1; clr = 1'b0; addr = '0; idle();
    repeat (3) @(negedge clk);
    // R12: reset state
    check_eq("R12", int'(viol), 0);
    check_eq("R12", int'(viol_cnt), 0);
    check_eq("R12", int'(viol_pulse), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 R2: window length, enable lead and closing signal
    for (int wl = 1; wl <= 5; wl++)
      for (int cl = 0; cl <= 2; cl++)
        for (int em = 0; em <= 2; em++)
          run_write(wl, cl, 3, 3, 2, em, NONE, 1'b0);

    // R3 R6 R7: lane lead, drive lead and drive hold
    for (int bl = 0; bl <= 3; bl++)
      for (int hl = 0; hl <= 3; hl++)
        for (int hh = 0; hh <= 2; hh++)
          run_write(4, 2, bl, hl, hh, 0, NONE, 1'b0);

    // R4 R5: address move around the closing sample
    for (int em = 0; em <= 1; em++)
      for (int off = -5; off <= 3; off++)
        run_write(4, 2, 3, 3, 2, em, off, 1'b0);

    // R8: output strobe low during writes
    run_write(4, 2, 3, 3, 2, 1, NONE, 1'b1);
    run_write(4, 2, 3, 3, 2, 0, NONE, 1'b1);

    // R8 R10 R11: ten contention samples saturate the count
    pulses = 0;
    @(negedge clk); idle(); clr = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      clr = 1'b0;
      if (viol_pulse) pulses++;
      sel_a_n = 1'b0; sel_b = 1'b1; ostrobe_n = 1'b0; host_drv = 1'b1;
    end
    @(negedge clk); idle();
    if (viol_pulse) pulses++;
    repeat (3) begin
      @(negedge clk);
      if (viol_pulse) pulses++;
    end
    check_eq("R8", int'(viol), 8'h80);
    check_eq("R10", int'(viol_cnt), 7);
    check_eq("R11", pulses, 10);

    // R9 R10 R11: clear wins over a same-sample violation
    @(negedge clk);
    clr = 1'b1; sel_a_n = 1'b0; sel_b = 1'b1; ostrobe_n = 1'b0; host_drv = 1'b1;
    @(negedge clk); clr = 1'b0; idle();
    check_eq("R9", int'(viol), 0);
    check_eq("R10", int'(viol_cnt), 0);
    check_eq("R11", int'(viol_pulse), 1);
    @(negedge clk);
    check_eq("R11", int'(viol_pulse), 0);
    check_eq("R9", int'(viol), 0);

    // R8: host drive with output strobe low but chip deselected
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; ostrobe_n = 1'b0; host_drv = 1'b1;
    repeat (5) @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    check_eq("R8", int'(viol), 0);
    check_eq("R10", int'(viol_cnt), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule